// File: doc/BRIEF.md
# Voltage/Frequency Operating-Point Sequencer

This block moves a processor core from one programmed voltage/frequency operating point to another in a safe order. Each point is an entry in a small table: a clock-generator frequency code and a regulator voltage code (VID). A higher table index always means a higher point, with a higher frequency and a higher voltage. A software request names a target index. A thermal trip asks for index 0, the lowest point, and a thermal trip outranks software.

When the target is lower than the current point, the block first stalls execution and retunes the clock generator, waiting for it to report lock. It then lets execution resume and walks the voltage code down. When the target is higher, the voltage code is walked up first, and only then is execution stalled while the clock generator retunes. The voltage code moves by one step at a time, never faster than one step per programmed number of cycles. Execution is stalled only while the clock generator relocks.

Requests that arrive during a transition are held in a single-entry slot, and a newer request replaces an older one there. A missing lock indication is bounded by a timeout, which records a sticky error.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, busy, halt and lock_err are 0, cur_idx is 0, pll_fsel equals the frequency code of entry 0, and vid equals the parameter VID_RST.
- R2: For a target index below cur_idx, the frequency code changes first, with halt high until the relock completes. Only then does vid move, down to the target's VID. At completion, cur_idx, pll_fsel and vid all match the target entry.
- R3: For a target index above cur_idx, vid first ramps to the target's VID. Only after that does the frequency code change under halt. At completion, cur_idx, pll_fsel and vid all match the target entry.
- R4: vid changes by exactly one code per change. Two changes are never fewer than max(slew_div,1) clock cycles apart.
- R5: halt is high only while the clock generator relocks, and vid never moves while halt is high. halt is held until pll_locked is seen high, starting from the second cycle after the frequency code changes. With a lock arriving L cycles after the change, halt lasts L+1 cycles.
- R6: If no lock arrives, halt is released after lock_tmo+1 cycles. The transition then completes, and lock_err becomes 1 and stays 1 until reset.
- R7: A request for the current index starts no transition: busy and halt stay 0, and the outputs do not change.
- R8: Requests that arrive while busy are held. Only the most recent one is serviced, once the current transition completes.
- R9: A thermal trip (therm_trip high for a cycle) makes index 0 the pending target and replaces any pending software request. Software requests that arrive while that thermal target is still pending are discarded.
- R10: busy is high from the start of a transition until its completion. Between two transitions, busy is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_freq_tbl | input | NPTS*FSELW | Frequency code of entry i at bits [i*FSELW +: FSELW] |
| op_vid_tbl | input | NPTS*VIDW | Voltage code of entry i at bits [i*VIDW +: VIDW] |
| slew_div | input | DIVW | Minimum cycles between voltage steps (0 is treated as 1) |
| lock_tmo | input | TOW | Relock timeout in cycles |
| req_valid | input | 1 | Software request strobe |
| req_idx | input | IDXW | Requested table index |
| therm_trip | input | 1 | Thermal trip, forces index 0 |
| pll_locked | input | 1 | Lock indication from the clock generator |
| halt | output | 1 | Execution stall while relocking |
| pll_fsel | output | FSELW | Frequency code driven to the clock generator |
| vid | output | VIDW | Voltage code driven to the regulator |
| cur_idx | output | IDXW | Index of the operating point last reached |
| busy | output | 1 | A transition is in progress |
| lock_err | output | 1 | Sticky relock timeout flag |

## Verification
Some rules are checked by assertions on every cycle. These cover the one-code voltage steps and their minimum spacing, and that vid holds while halt is high. They also cover that the frequency code changes only under halt, that the voltage reaches its target before an upward relock, and that the frequency is already final during a downward ramp. The relock counter staying within the timeout, the sticky error and the capture of a thermal trip are checked the same way. Other behaviour can only be shown by the bench's scenarios. These include the order in which frequency and voltage move, the exact stall length with and without a lock, the merging of requests during a transition, the override of pending software by a thermal trip, and the absence of any action for a request to the current point.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RELOCK = 2'd1,
    SQ_RAMP   = 2'd2
  } seq_st_t;
endpackage

// File: rtl/dvfs_req_hold.sv
module dvfs_req_hold #(
  parameter int IDXW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [IDXW-1:0] req_idx,
  input  logic            therm_trip,
  input  logic            take,
  output logic            pend_valid,
  output logic [IDXW-1:0] pend_idx
);
  logic            pend_therm;
  logic            v_n, t_n;
  logic [IDXW-1:0] i_n;

  always_comb begin
    v_n = pend_valid;
    i_n = pend_idx;
    t_n = pend_therm;
    if (take) begin
      v_n = 1'b0;
      t_n = 1'b0;
    end
    if (therm_trip) begin
      v_n = 1'b1;
      i_n = '0;
      t_n = 1'b1;
    end else if (req_valid && !t_n) begin
      v_n = 1'b1;
      i_n = req_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_idx   <= '0;
      pend_therm <= 1'b0;
    end else begin
      pend_valid <= v_n;
      pend_idx   <= i_n;
      pend_therm <= t_n;
    end
  end

  AST_THERM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    therm_trip |=> (pend_valid && pend_idx == '0)); // R9
endmodule

// File: rtl/dvfs_vid_ramp.sv
module dvfs_vid_ramp #(
  parameter int              VIDW    = 6,
  parameter int              DIVW    = 8,
  parameter logic [VIDW-1:0] VID_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [VIDW-1:0] tgt_vid,
  input  logic [DIVW-1:0] div,
  output logic [VIDW-1:0] vid,
  output logic            at_tgt
);
  logic [DIVW-1:0] div_eff, cnt, cnt_n;
  logic [VIDW-1:0] vid_n;
  logic            step;

  assign div_eff = (div == '0) ? DIVW'(1) : div;
  assign at_tgt  = (vid == tgt_vid);
  assign step    = en && !at_tgt && (cnt >= div_eff - DIVW'(1));

  always_comb begin
    cnt_n = (en && !at_tgt && !step) ? cnt + DIVW'(1) : '0;
    vid_n = vid;
    if (step) vid_n = (tgt_vid > vid) ? vid + VIDW'(1) : vid - VIDW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      vid <= VID_RST;
    end else begin
      cnt <= cnt_n;
      vid <= vid_n;
    end
  end

  // cycles since the last voltage step, saturating; observation only
  logic [DIVW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap <= '1;
    else if (vid_n != vid)   gap <= '0;
    else if (gap != '1)      gap <= gap + DIVW'(1);
  end

  AST_VID_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vid) |-> (vid == $past(vid) + VIDW'(1) || vid == $past(vid) - VIDW'(1))); // R4
  AST_SLEW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vid) |-> ($past(gap) >= div_eff - DIVW'(1))); // R4
endmodule

// File: rtl/dvfs_lock_wait.sv
module dvfs_lock_wait #(
  parameter int TOW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           pll_locked,
  input  logic [TOW-1:0] tmo,
  output logic           done,
  output logic           timed_out
);
  logic [TOW-1:0] cnt, cnt_n;
  logic           locked_ok, expired;

  assign locked_ok = active && pll_locked && (cnt != '0);
  assign expired   = active && (cnt >= tmo);
  assign done      = locked_ok || expired;
  assign timed_out = expired && !locked_ok;

  always_comb begin
    cnt_n = '0;
    if (active) cnt_n = (cnt == '1) ? cnt : cnt + TOW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= tmo)); // R6
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int              NPTS    = 4,
  parameter int              FSELW   = 4,
  parameter int              VIDW    = 6,
  parameter int              DIVW    = 8,
  parameter int              TOW     = 8,
  parameter logic [VIDW-1:0] VID_RST = 6'd10,
  localparam int             IDXW    = (NPTS > 1) ? $clog2(NPTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPTS*FSELW-1:0] op_freq_tbl,
  input  logic [NPTS*VIDW-1:0]  op_vid_tbl,
  input  logic [DIVW-1:0]       slew_div,
  input  logic [TOW-1:0]        lock_tmo,
  input  logic                  req_valid,
  input  logic [IDXW-1:0]       req_idx,
  input  logic                  therm_trip,
  input  logic                  pll_locked,
  output logic                  halt,
  output logic [FSELW-1:0]      pll_fsel,
  output logic [VIDW-1:0]       vid,
  output logic [IDXW-1:0]       cur_idx,
  output logic                  busy,
  output logic                  lock_err
);
  seq_st_t         st, st_n;
  logic            dir_up, dir_n;
  logic [IDXW-1:0] tgt_idx, tgt_n, cur_n, fsel_idx, fsel_n;
  logic            err_n;
  logic            pend_valid, take;
  logic [IDXW-1:0] pend_idx;
  logic            lk_done, lk_tmo;
  logic            at_tgt;
  logic [VIDW-1:0] tgt_vid;

  assign tgt_vid  = op_vid_tbl[tgt_idx*VIDW +: VIDW];
  assign pll_fsel = op_freq_tbl[fsel_idx*FSELW +: FSELW];
  assign halt     = (st == SQ_RELOCK);
  assign busy     = (st != SQ_IDLE);
  assign take     = (st == SQ_IDLE) && pend_valid;

  dvfs_req_hold #(.IDXW(IDXW)) u_hold (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .therm_trip(therm_trip), .take(take),
    .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  dvfs_vid_ramp #(.VIDW(VIDW), .DIVW(DIVW), .VID_RST(VID_RST)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(st == SQ_RAMP), .tgt_vid(tgt_vid),
    .div(slew_div), .vid(vid), .at_tgt(at_tgt)
  );

  dvfs_lock_wait #(.TOW(TOW)) u_lock (
    .clk(clk), .rst_n(rst_n), .active(st == SQ_RELOCK), .pll_locked(pll_locked),
    .tmo(lock_tmo), .done(lk_done), .timed_out(lk_tmo)
  );

  always_comb begin
    st_n   = st;
    dir_n  = dir_up;
    tgt_n  = tgt_idx;
    cur_n  = cur_idx;
    fsel_n = fsel_idx;
    err_n  = lock_err;
    unique case (st)
      SQ_IDLE: begin
        if (pend_valid && pend_idx != cur_idx) begin
          tgt_n = pend_idx;
          if (pend_idx < cur_idx) begin
            dir_n  = 1'b0;
            fsel_n = pend_idx;
            st_n   = SQ_RELOCK;
          end else begin
            dir_n = 1'b1;
            st_n  = SQ_RAMP;
          end
        end
      end
      SQ_RELOCK: begin
        if (lk_done) begin
          if (lk_tmo) err_n = 1'b1;
          if (dir_up) begin
            st_n  = SQ_IDLE;
            cur_n = tgt_idx;
          end else begin
            st_n = SQ_RAMP;
          end
        end
      end
      SQ_RAMP: begin
        if (at_tgt) begin
          if (dir_up) begin
            fsel_n = tgt_idx;
            st_n   = SQ_RELOCK;
          end else begin
            st_n  = SQ_IDLE;
            cur_n = tgt_idx;
          end
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      dir_up   <= 1'b0;
      tgt_idx  <= '0;
      cur_idx  <= '0;
      fsel_idx <= '0;
      lock_err <= 1'b0;
    end else begin
      st       <= st_n;
      dir_up   <= dir_n;
      tgt_idx  <= tgt_n;
      cur_idx  <= cur_n;
      fsel_idx <= fsel_n;
      lock_err <= err_n;
    end
  end

  AST_HALT_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && $past(halt)) |-> $stable(vid)); // R5
  AST_FSEL_UNDER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsel_idx) |-> halt); // R2
  AST_UP_VOLT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && dir_up) |-> (vid == tgt_vid)); // R3
  AST_DOWN_FREQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RAMP && !dir_up) |-> (fsel_idx == tgt_idx)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> lock_err); // R6
endmodule

// File: tb/dvfs_seq_test.sv
module dvfs_seq_test;
  localparam int NPTS = 4, FSELW = 4, VIDW = 6, DIVW = 8, TOW = 8, IDXW = 2;
  localparam int DIV = 3, TMO = 20, LAT = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [NPTS*FSELW-1:0] op_freq_tbl = {4'd14, 4'd9, 4'd5, 4'd2};
  logic [NPTS*VIDW-1:0]  op_vid_tbl  = {6'd34, 6'd24, 6'd16, 6'd10};
  logic [DIVW-1:0] slew_div = DIVW'(DIV);
  logic [TOW-1:0]  lock_tmo = TOW'(TMO);
  logic req_valid = 1'b0, therm_trip = 1'b0, pll_locked = 1'b1, pll_ok = 1'b1;
  logic [IDXW-1:0] req_idx = '0;
  logic halt, busy, lock_err;
  logic [FSELW-1:0] pll_fsel;
  logic [VIDW-1:0] vid;
  logic [IDXW-1:0] cur_idx;

  always #2.5 clk = ~clk;

  dvfs_seq uut (
    .clk(clk), .rst_n(rst_n), .op_freq_tbl(op_freq_tbl), .op_vid_tbl(op_vid_tbl),
    .slew_div(slew_div), .lock_tmo(lock_tmo), .req_valid(req_valid), .req_idx(req_idx),
    .therm_trip(therm_trip), .pll_locked(pll_locked), .halt(halt), .pll_fsel(pll_fsel),
    .vid(vid), .cur_idx(cur_idx), .busy(busy), .lock_err(lock_err)
  );

  int checks = 0, failures = 0, completions = 0, last_halt = 0;
  int slew_viol = 0, step_viol = 0, halt_viol = 0;
  int exp_idx[$];
  int exp_ord[$];
  bit finished = 1'b0;

  function automatic int f_of(int i); return int'(op_freq_tbl[i*FSELW +: FSELW]); endfunction
  function automatic int v_of(int i); return int'(op_vid_tbl[i*VIDW +: VIDW]); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clock generator model: lock drops on a code change, returns LAT cycles later
  initial begin
    logic [FSELW-1:0] pf;
    int cnt;
    pf = 'x;
    cnt = LAT;
    forever begin
      @(negedge clk);
      if (pll_fsel !== pf) cnt = 0;
      else if (cnt < LAT) cnt++;
      pf = pll_fsel;
      pll_locked = pll_ok && (cnt >= LAT);
    end
  end

  // monitor and scoreboard: order 1 = voltage moved first, 2 = frequency first
  initial begin
    logic [VIDW-1:0] pv;
    logic [FSELW-1:0] pfs;
    logic pb;
    int gap, ord, hcnt;
    @(posedge rst_n);
    @(negedge clk);
    pv = vid; pfs = pll_fsel; pb = busy; gap = 1000; ord = 0; hcnt = 0;
    forever begin
      @(negedge clk);
      if (vid != pv) begin
        if (halt) halt_viol++;
        if (gap + 1 < DIV) slew_viol++;
        if (!(int'(vid) == int'(pv) + 1 || int'(vid) == int'(pv) - 1)) step_viol++;
        gap = 0;
        if (busy && ord == 0) ord = 1;
      end else begin
        gap++;
        if (pll_fsel != pfs && busy && ord == 0) ord = 2;
      end
      if (halt) hcnt++;
      if (pb && !busy) begin
        completions++;
        last_halt = hcnt;
        if (exp_idx.size() == 0) chk(1'b0, "R8 unexpected completion", int'(cur_idx), -1);
        else begin
          int ei, eo;
          ei = exp_idx.pop_front();
          eo = exp_ord.pop_front();
          chk(int'(cur_idx) == ei, "R2/R3 cur_idx", int'(cur_idx), ei);
          chk(int'(vid) == v_of(ei), "R2/R3 vid", int'(vid), v_of(ei));
          chk(int'(pll_fsel) == f_of(ei), "R2/R3 pll_fsel", int'(pll_fsel), f_of(ei));
          chk(ord == eo, "R2/R3 step order", ord, eo);
        end
        ord = 0; hcnt = 0;
      end
      pv = vid; pfs = pll_fsel; pb = busy;
    end
  end

  task automatic send_req(int idx);
    @(negedge clk); req_valid = 1'b1; req_idx = IDXW'(idx);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic pulse_therm();
    @(negedge clk); therm_trip = 1'b1;
    @(negedge clk); therm_trip = 1'b0;
  endtask

  task automatic expect_tr(int idx, int ord);
    exp_idx.push_back(idx);
    exp_ord.push_back(ord);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    while (busy || exp_idx.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(halt == 1'b0, "R1 halt", int'(halt), 0);
    chk(cur_idx == 0, "R1 cur_idx", int'(cur_idx), 0);
    chk(int'(vid) == 10, "R1 vid", int'(vid), 10);
    chk(int'(pll_fsel) == f_of(0), "R1 pll_fsel", int'(pll_fsel), f_of(0));
    chk(lock_err == 1'b0, "R1 lock_err", int'(lock_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 upward step, R10 busy framing via completion
    expect_tr(2, 1); send_req(2); drain();
    // R2 downward step, R5 stall length with lock after LAT cycles
    expect_tr(1, 2); send_req(1); drain();
    chk(last_halt == LAT + 1, "R5 halt cycles", last_halt, LAT + 1);
    chk(lock_err == 1'b0, "R6 no error with lock", int'(lock_err), 0);

    // R7 request for current point
    begin
      int seen_busy;
      seen_busy = 0;
      send_req(1);
      repeat (10) begin
        @(negedge clk);
        if (busy || halt) seen_busy++;
      end
      chk(seen_busy == 0, "R7 no transition", seen_busy, 0);
      chk(cur_idx == 1 && int'(vid) == v_of(1), "R7 outputs unchanged", int'(vid), v_of(1));
    end

    // R8 latest held request wins
    expect_tr(3, 1); expect_tr(2, 2);
    send_req(3); repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R10 busy during transition", int'(busy), 1);
    send_req(0); send_req(2); drain();

    // R9 thermal trip overrides pending and later software requests
    expect_tr(3, 1); expect_tr(0, 2);
    send_req(3); repeat (2) @(negedge clk);
    send_req(1); pulse_therm(); send_req(2); drain();
    chk(cur_idx == 0, "R9 ends at lowest point", int'(cur_idx), 0);

    // R9 thermal trip while idle
    expect_tr(1, 1); send_req(1); drain();
    expect_tr(0, 2); pulse_therm(); drain();

    // R6 relock timeout
    pll_ok = 1'b0;
    expect_tr(2, 1); send_req(2); drain();
    chk(last_halt == TMO + 1, "R6 halt cycles on timeout", last_halt, TMO + 1);
    chk(lock_err == 1'b1, "R6 lock_err set", int'(lock_err), 1);
    pll_ok = 1'b1;
    expect_tr(1, 2); send_req(1); drain();
    chk(lock_err == 1'b1, "R6 lock_err sticky", int'(lock_err), 1);

    // R4 slew and step size, R5 no ramp under halt
    chk(slew_viol == 0, "R4 slew spacing", slew_viol, 0);
    chk(step_viol == 0, "R4 single-code steps", step_viol, 0);
    chk(halt_viol == 0, "R5 vid held under halt", halt_viol, 0);
    chk(completions == 10, "R8 completion count", completions, 10);
    summary();
  end
endmodule